// File: doc/BRIEF.md
# Time Event Capture and Interrupt Unit

This block sits beside a free-running 64-bit system time counter and turns time-related happenings into latched events. Three kinds are handled. A programmable 64-bit target is compared with the running time. Two auxiliary strobe inputs, one for a slave-side event and one for a master-side event, each copy the current time into their own capture register. A pulse-per-second input is the fourth source. Each happening sets its own bit in a sticky event register.

Software clears an event bit by writing 1 to it. A per-source mask in the control word decides which pending events drive the single interrupt line. The register write port selects one of four 32-bit words: control, event, target low and target high. Event status, the mask, both capture registers and the interrupt are brought out directly as outputs.

Top module: `tevt_unit`

## Requirements
- R1: After reset, the event bits and mask bits are 0, `irq` is 0, both capture registers are 0, and the target is all ones.
- R2: Event bit 1 (target pending) sets on every clock in which `sys_time`, compared unsigned over 64 bits, is greater than or equal to the target.
- R3: A rising edge on `strobe_slv` copies `sys_time` into `snap_slv` at that clock edge and sets event bit 2. Holding the strobe high causes no further capture.
- R4: A rising edge on `strobe_mst` copies `sys_time` into `snap_mst` at that clock edge and sets event bit 3. Holding the strobe high causes no further capture.
- R5: A rising edge on `pps_in` sets event bit 4.
- R6: A write to the event word (select 1) clears every event bit whose data bit is 1 and leaves every event bit whose data bit is 0 unchanged.
- R7: When a source sets an event bit in the same clock as a write-1 clear of that bit, the bit stays 1.
- R8: When event bit 1 is cleared while the time is still at or past the target, it reads 1 again straight after the write. Once the time is below the target, the clear takes effect.
- R9: `irq` is 1 exactly when, for some n in 1..4, event bit n and control bit n are both 1. Bit 0 of the event and control words is always 0.
- R10: Write select 0 loads the mask from data bits 4:1. Select 2 loads target bits 31:0 and select 3 loads target bits 63:32. Each write takes effect at the clock edge where `wr_en` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_time | input | 64 | Running system time |
| strobe_slv | input | 1 | Slave-side auxiliary strobe |
| strobe_mst | input | 1 | Master-side auxiliary strobe |
| pps_in | input | 1 | Pulse-per-second input |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Word select: 0 control, 1 event, 2 target low, 3 target high |
| wr_data | input | 32 | Write data |
| evt_status | output | 5 | Event bits, bit 0 reads 0 |
| evt_mask | output | 5 | Mask bits, bit 0 reads 0 |
| snap_slv | output | 64 | Slave-side capture register |
| snap_mst | output | 64 | Master-side capture register |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check how each event bit evolves: a set always lands, a clear with no competing set always lands, and an untouched bit holds. They also check that every edge captures the time of that edge, that a strobe edge fires only once, that a time at or past the target marks the bit pending, and that an all-zero mask keeps the interrupt low. The bench scenarios are needed for the rest. A sweep over all mask and event combinations shows the interrupt decode. Boundary times across the word split of the target show the unsigned compare. Colliding clears show the set-wins rule. Only the scenarios show that the pending bit re-arms after a clear.

// File: rtl/tevt_pkg.sv
package tevt_pkg;
  localparam int TIME_W  = 64;
  localparam int WORD_W  = 32;
  localparam int N_EVT   = 4;
  localparam int EVT_LSB = 1;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL   = 2'd0,
    SEL_EVENT  = 2'd1,
    SEL_TGT_LO = 2'd2,
    SEL_TGT_HI = 2'd3
  } reg_sel_e;

  // event vector index (bit position minus EVT_LSB)
  localparam int IX_TGT = 0;
  localparam int IX_SLV = 1;
  localparam int IX_MST = 2;
  localparam int IX_PPS = 3;
endpackage

// File: rtl/tevt_edge.sv
module tevt_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb begin
    prev_d = lvl;
    rise   = lvl & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3: a held level produces one edge only
    assert_one_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && lvl[i]) |=> (!rise[i] || !$past(lvl[i])));
  end
endmodule

// File: rtl/tevt_snap.sv
module tevt_snap #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] time_in,
  output logic [W-1:0] snap
);
  logic [W-1:0] snap_q;
  logic [W-1:0] snap_d;

  always_comb begin
    snap_d = snap_q;
    if (cap) snap_d = time_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  assign snap = snap_q;

  // R3/R4: each capture holds the time seen at its edge
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (snap == $past(time_in)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(snap));
endmodule

// File: rtl/tevt_status.sv
module tevt_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] st,
  output logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] st_q, st_d;
  logic [N-1:0] mask_q, mask_d;

  always_comb begin
    // set wins over a same-cycle clear
    st_d   = (st_q & ~clr) | set;
    mask_d = mask_q;
    if (mask_we) mask_d = mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      mask_q <= '0;
    end else begin
      st_q   <= st_d;
      mask_q <= mask_d;
    end
  end

  assign st   = st_q;
  assign mask = mask_q;
  assign irq  = |(st_q & mask_q);

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> st[i]);
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !st[i]);
    assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[i] && !set[i]) |=> $stable(st[i]));
  end

  assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: rtl/tevt_unit.sv
module tevt_unit
  import tevt_pkg::*;
#(
  parameter int TW = TIME_W,
  parameter int DW = WORD_W,
  parameter int NE = N_EVT,
  parameter int SW = SEL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   sys_time,
  input  logic            strobe_slv,
  input  logic            strobe_mst,
  input  logic            pps_in,
  input  logic            wr_en,
  input  logic [SW-1:0]   wr_sel,
  input  logic [DW-1:0]   wr_data,
  output logic [NE:0]     evt_status,
  output logic [NE:0]     evt_mask,
  output logic [TW-1:0]   snap_slv,
  output logic [TW-1:0]   snap_mst,
  output logic            irq
);
  localparam int NSTB = 3;
  localparam int HI_W = TW - DW;

  logic [TW-1:0]   tgt_q, tgt_d;
  logic [NSTB-1:0] stb_lvl, stb_rise;
  logic [NE-1:0]   ev_set, ev_clr, ev_st, ev_mask;
  logic            tgt_hit;
  logic            we_ctrl, we_evt, we_lo, we_hi;

  always_comb begin
    we_ctrl = wr_en && (wr_sel == SEL_CTRL);
    we_evt  = wr_en && (wr_sel == SEL_EVENT);
    we_lo   = wr_en && (wr_sel == SEL_TGT_LO);
    we_hi   = wr_en && (wr_sel == SEL_TGT_HI);
    tgt_d   = tgt_q;
    if (we_lo) tgt_d[DW-1:0]  = wr_data;
    if (we_hi) tgt_d[TW-1:DW] = wr_data[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= '1;
    else        tgt_q <= tgt_d;
  end

  assign tgt_hit = (sys_time >= tgt_q);
  assign stb_lvl = {pps_in, strobe_mst, strobe_slv};

  tevt_edge #(.N(NSTB)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(stb_lvl), .rise(stb_rise)
  );

  tevt_snap #(.W(TW)) u_snap_slv (
    .clk(clk), .rst_n(rst_n), .cap(stb_rise[0]), .time_in(sys_time), .snap(snap_slv)
  );

  tevt_snap #(.W(TW)) u_snap_mst (
    .clk(clk), .rst_n(rst_n), .cap(stb_rise[1]), .time_in(sys_time), .snap(snap_mst)
  );

  always_comb begin
    ev_set         = '0;
    ev_set[IX_TGT] = tgt_hit;
    ev_set[IX_SLV] = stb_rise[0];
    ev_set[IX_MST] = stb_rise[1];
    ev_set[IX_PPS] = stb_rise[2];
    ev_clr         = we_evt ? wr_data[EVT_LSB +: NE] : '0;
  end

  tevt_status #(.N(NE)) u_status (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(ev_clr),
    .mask_we(we_ctrl), .mask_wdata(wr_data[EVT_LSB +: NE]),
    .st(ev_st), .mask(ev_mask), .irq(irq)
  );

  assign evt_status = {ev_st, 1'b0};
  assign evt_mask   = {ev_mask, 1'b0};

  // R2: time at or past the target marks the pending bit
  assert_tgt_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_time >= tgt_q) |=> evt_status[1]);
  // R10: a target-low write lands on the low word
  assert_tgt_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    we_lo |=> (tgt_q[DW-1:0] == $past(wr_data)));
endmodule

// File: tb/sim_tevt_unit.sv
module sim_tevt_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] sys_time;
  logic        strobe_slv, strobe_mst, pps_in;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [4:0]  evt_status, evt_mask;
  logic [63:0] snap_slv, snap_mst;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tevt_unit u0 (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time),
    .strobe_slv(strobe_slv), .strobe_mst(strobe_mst), .pps_in(pps_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .evt_status(evt_status), .evt_mask(evt_mask),
    .snap_slv(snap_slv), .snap_mst(snap_mst), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic set_target(input logic [63:0] t);
    wr(2'd2, t[31:0]);
    wr(2'd3, t[63:32]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sys_time = '0; strobe_slv = 0; strobe_mst = 0; pps_in = 0;
    wr_en = 0; wr_sel = '0; wr_data = '0;
    #(CLK_PERIOD * 3);
    #1 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 status", {59'd0, evt_status}, 64'd0);
    chk("R1 mask", {59'd0, evt_mask}, 64'd0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R1 snap_slv", snap_slv, 64'd0);
    chk("R1 snap_mst", snap_mst, 64'd0);
    sys_time = 64'hFFFF_FFFF_FFFF_FFFE;
    tick();
    chk("R1 target all ones (below)", {59'd0, evt_status}, 64'd0);

    // R2/R10 compare across the word split
    sys_time = 64'd0;
    set_target(64'h0000_0001_0000_0000);
    sys_time = 64'h0000_0000_FFFF_FFFF;
    tick();
    chk("R2 below target", {63'd0, evt_status[1]}, 64'd0);
    sys_time = 64'h0000_0001_0000_0000;
    tick();
    chk("R2 R10 equal target", {63'd0, evt_status[1]}, 64'd1);
    // R8 re-arm while still past target
    wr(2'd1, 32'h2);
    chk("R8 re-sets while matched", {63'd0, evt_status[1]}, 64'd1);
    sys_time = 64'h0000_0000_8000_0000;
    wr(2'd1, 32'h2);
    chk("R8 R6 clears when below", {63'd0, evt_status[1]}, 64'd0);
    sys_time = 64'hF000_0000_0000_0000;
    tick();
    chk("R2 unsigned large time", {63'd0, evt_status[1]}, 64'd1);
    sys_time = 64'd5;
    wr(2'd1, 32'h2);

    // R3/R4 capture sweep over several times, held strobes
    for (int k = 0; k < 8; k++) begin
      logic [63:0] t;
      t = 64'h0123_4567_89AB_CDEF * (k + 1);
      sys_time = t[63:32] == 32'h0000_0001 ? t : (t & 64'h0000_0000_FFFF_FFFF);
      strobe_slv = (k % 2 == 0);
      strobe_mst = (k % 2 == 1);
      tick();
      if (k % 2 == 0) begin
        chk("R3 slave capture", snap_slv, sys_time);
        chk("R3 slave event", {63'd0, evt_status[2]}, 64'd1);
      end else begin
        chk("R4 master capture", snap_mst, sys_time);
        chk("R4 master event", {63'd0, evt_status[3]}, 64'd1);
      end
      sys_time = sys_time + 64'd17;
      tick();
      chk("R3 R4 held strobe no recapture slv", snap_slv,
          (k % 2 == 0) ? sys_time - 64'd17 : snap_slv);
      chk("R3 R4 held strobe no recapture mst", snap_mst,
          (k % 2 == 1) ? sys_time - 64'd17 : snap_mst);
      strobe_slv = 0; strobe_mst = 0;
      wr(2'd1, 32'h1E);
    end
    sys_time = 64'd5;
    wr(2'd1, 32'h1E);

    // R5 pps
    pps_in = 1; tick();
    chk("R5 pps event", {63'd0, evt_status[4]}, 64'd1);
    pps_in = 0;
    // R6 write 0 leaves, write 1 clears
    wr(2'd1, 32'h0);
    chk("R6 zero write keeps", {63'd0, evt_status[4]}, 64'd1);
    wr(2'd1, 32'h10);
    chk("R6 one write clears", {63'd0, evt_status[4]}, 64'd0);

    // R7 set wins over same-cycle clear
    strobe_slv = 1;
    wr(2'd1, 32'h4);
    chk("R7 set beats clear", {63'd0, evt_status[2]}, 64'd1);
    strobe_slv = 0;
    wr(2'd1, 32'h4);
    chk("R7 later clear lands", {63'd0, evt_status[2]}, 64'd0);

    // R9/R10 exhaustive mask x event sweep
    set_target(64'd10);
    for (int m = 0; m < 16; m++) begin
      wr(2'd0, 32'(m << 1) | 32'h1);
      chk("R10 R9 mask load", {59'd0, evt_mask}, 64'(m << 1));
      for (int p = 0; p < 16; p++) begin
        sys_time = 64'd20; strobe_slv = 1; strobe_mst = 1; pps_in = 1;
        tick();
        sys_time = 64'd0; strobe_slv = 0; strobe_mst = 0; pps_in = 0;
        tick();
        wr(2'd1, 32'((~p & 15) << 1) | 32'h1);
        chk("R6 R9 status pattern", {59'd0, evt_status}, 64'(p << 1));
        chk("R9 irq decode", {63'd0, irq}, {63'd0, ((p & m) != 0)});
        wr(2'd1, 32'h1E);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule